// File: doc/BRIEF.md
# Partial Immediate Load Unit

This unit computes the next value of a 64-bit register for the family of immediate-load operations. It takes the register's present contents, a 16-bit immediate, a 3-bit operation code and the index of the destination register. It returns the value to be written back, together with a write-enable for the register file.

There are two groups of operations. The lane-insert group copies the immediate into one 16-bit lane and leaves the other three lanes as they were. The sign-fill group discards the old contents. It sign-extends the immediate, places it at a lane boundary, and fills every lower lane with zeros.

The unit is purely combinational. It sits between operand read and register write-back. Index 0 is the hardwired zero register, and a write addressed to it is suppressed.

Top module: `imm_load_unit`

## Requirements
- R1: With opSel[2]=0, opSel[1:0] selects lane n (bits 16n+15:16n, n=0..3), and newValue holds immValue in that lane.
- R2: With opSel[2]=0, every bit of newValue outside the selected lane equals the same bit of oldValue.
- R3: opSel=3'b100 gives newValue equal to immValue sign-extended to 64 bits (immValue[15] copied into bits 63:16).
- R4: opSel=3'b101 gives newValue equal to the sign-extended immediate shifted left by 16, so bits 15:0 are zero.
- R5: opSel=3'b110 and opSel=3'b111 give the sign-extended immediate shifted left by 32 and by 48 respectively, with zeros below and the sign bit copied above.
- R6: When destIdx is 0 (the zero register), writeEn is 0 and newValue is all zeros, whatever the operation.
- R7: When destIdx is nonzero, writeEn is 1.
- R8: The outputs depend only on the present inputs, with no clock and no stored state, and follow an input change within the same clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| oldValue | input | 64 | Present contents of the destination register |
| immValue | input | 16 | Immediate operand |
| opSel | input | 3 | Bit 2: sign-fill (1) or lane-insert (0); bits 1:0: lane index |
| destIdx | input | 4 | Destination register index; 0 is the zero register |
| newValue | output | 64 | Value to write back |
| writeEn | output | 1 | Write-enable for the register file |

## Verification
Every result of this unit is due in the cycle that its inputs are applied. The bench drives each stimulus on the falling edge of its own clock. It samples newValue and writeEn a short settle time later, still inside the same half period, so no check ever waits for a rising edge. For R8, a directed test changes the inputs a second time between two edges and checks that the outputs have already followed the change before the next edge.

// File: rtl/imm_load_pkg.sv
package imm_load_pkg;
  localparam int DATA_W     = 64;
  localparam int LANE_W     = 16;
  localparam int LANE_CNT   = DATA_W / LANE_W;
  localparam int LANE_SEL_W = $clog2(LANE_CNT);
  localparam int OP_W       = LANE_SEL_W + 1;
  localparam int REG_IDX_W  = 4;
  localparam int ZERO_IDX   = 0;

  // Per-lane strobes from control to datapath
  typedef struct packed {
    logic [LANE_CNT-1:0] laneHot;   // lane receives the immediate
    logic [LANE_CNT-1:0] laneClear; // lane forced to zero
    logic [LANE_CNT-1:0] laneFill;  // lane filled with the sign bit
    logic                writeEn;
  } laneStrobes_t;
endpackage

// File: rtl/imm_load_ctrl.sv
module imm_load_ctrl
  import imm_load_pkg::*;
(
  input  logic [OP_W-1:0]      opSel,
  input  logic [REG_IDX_W-1:0] destIdx,
  output laneStrobes_t         strobes
);
  logic                  signMode;
  logic [LANE_SEL_W-1:0] laneIdx;

  assign signMode = opSel[OP_W-1];
  assign laneIdx  = opSel[LANE_SEL_W-1:0];

  for (genvar l = 0; l < LANE_CNT; l++) begin : g_lane
    assign strobes.laneHot[l]   = (laneIdx == LANE_SEL_W'(l));
    assign strobes.laneClear[l] = signMode && (LANE_SEL_W'(l) < laneIdx);
    assign strobes.laneFill[l]  = signMode && (LANE_SEL_W'(l) > laneIdx);
  end

  assign strobes.writeEn = (destIdx != REG_IDX_W'(ZERO_IDX));

  always_comb begin
    if (!$isunknown(opSel)) begin
      // R1
      lane_onehot_chk: assert ($onehot(strobes.laneHot));
      // R2
      keep_no_strobe_chk: assert (signMode || (strobes.laneClear == '0 && strobes.laneFill == '0));
    end
  end
endmodule

// File: rtl/imm_load_datapath.sv
module imm_load_datapath
  import imm_load_pkg::*;
(
  input  logic [DATA_W-1:0] oldValue,
  input  logic [LANE_W-1:0] immValue,
  input  laneStrobes_t      strobes,
  output logic [DATA_W-1:0] newValue
);
  logic [LANE_W-1:0] signLane;
  assign signLane = {LANE_W{immValue[LANE_W-1]}};

  for (genvar l = 0; l < LANE_CNT; l++) begin : g_lane
    logic [LANE_W-1:0] laneOut;
    always_comb begin
      if (!strobes.writeEn)            laneOut = '0;
      else if (strobes.laneHot[l])     laneOut = immValue;
      else if (strobes.laneClear[l])   laneOut = '0;
      else if (strobes.laneFill[l])    laneOut = signLane;
      else                             laneOut = oldValue[l*LANE_W +: LANE_W];
    end
    assign newValue[l*LANE_W +: LANE_W] = laneOut;
  end

  always_comb begin
    if (!$isunknown(strobes)) begin
      // R6
      zero_dest_chk: assert (strobes.writeEn || newValue == '0);
    end
  end
endmodule

// File: rtl/imm_load_unit.sv
module imm_load_unit
  import imm_load_pkg::*;
(
  input  logic [DATA_W-1:0]    oldValue,
  input  logic [LANE_W-1:0]    immValue,
  input  logic [OP_W-1:0]      opSel,
  input  logic [REG_IDX_W-1:0] destIdx,
  output logic [DATA_W-1:0]    newValue,
  output logic                 writeEn
);
  laneStrobes_t strobes;

  imm_load_ctrl u_ctrl (
    .opSel   (opSel),
    .destIdx (destIdx),
    .strobes (strobes)
  );

  imm_load_datapath u_dp (
    .oldValue (oldValue),
    .immValue (immValue),
    .strobes  (strobes),
    .newValue (newValue)
  );

  assign writeEn = strobes.writeEn;

  // Reference values for the checks below, built by shifting
  logic [DATA_W-1:0] laneMask;
  logic [DATA_W-1:0] signShifted;
  logic [DATA_W-1:0] immShifted;
  always_comb begin
    laneMask    = {{(DATA_W-LANE_W){1'b0}}, {LANE_W{1'b1}}} << (LANE_W * opSel[LANE_SEL_W-1:0]);
    immShifted  = {{(DATA_W-LANE_W){1'b0}}, immValue} << (LANE_W * opSel[LANE_SEL_W-1:0]);
    signShifted = {{(DATA_W-LANE_W){immValue[LANE_W-1]}}, immValue} << (LANE_W * opSel[LANE_SEL_W-1:0]);
  end

  always_comb begin
    if (!$isunknown({oldValue, immValue, opSel, destIdx})) begin
      // R1
      lane_insert_chk: assert (!(writeEn && !opSel[OP_W-1]) || (newValue & laneMask) == immShifted);
      // R2
      lane_keep_chk: assert (!(writeEn && !opSel[OP_W-1]) || ((newValue ^ oldValue) & ~laneMask) == '0);
      // R3, R4, R5
      sign_fill_chk: assert (!(writeEn && opSel[OP_W-1]) || newValue == signShifted);
      // R7
      write_en_chk: assert (writeEn == (destIdx != '0));
    end
  end
endmodule

// File: tb/imm_load_unit_tb.sv
module imm_load_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] oldValue;
  logic [15:0] immValue;
  logic [2:0]  opSel;
  logic [3:0]  destIdx;
  logic [63:0] newValue;
  logic        writeEn;

  int testsRun = 0;
  int testsFailed = 0;

  always #5 clk = ~clk;

  imm_load_unit u_dut (
    .oldValue (oldValue),
    .immValue (immValue),
    .opSel    (opSel),
    .destIdx  (destIdx),
    .newValue (newValue),
    .writeEn  (writeEn)
  );

  typedef struct packed {
    logic [63:0] oldV;
    logic [15:0] imm;
    logic [2:0]  op;
    logic [3:0]  dest;
    logic [63:0] expV;
    logic        expWe;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    // R1/R2 lane inserts
    '{64'h1111_2222_3333_4444, 16'hABCD, 3'd0, 4'd1,  64'h1111_2222_3333_ABCD, 1'b1, 8'd1},
    '{64'h1111_2222_3333_4444, 16'hABCD, 3'd1, 4'd2,  64'h1111_2222_ABCD_4444, 1'b1, 8'd1},
    '{64'h1111_2222_3333_4444, 16'hABCD, 3'd2, 4'd3,  64'h1111_ABCD_3333_4444, 1'b1, 8'd2},
    '{64'h1111_2222_3333_4444, 16'hABCD, 3'd3, 4'd4,  64'hABCD_2222_3333_4444, 1'b1, 8'd2},
    '{64'hFFFF_FFFF_FFFF_FFFF, 16'h0000, 3'd2, 4'd15, 64'hFFFF_0000_FFFF_FFFF, 1'b1, 8'd2},
    // R3 low-lane sign fill
    '{64'h1234_5678_9ABC_DEF0, 16'h8001, 3'd4, 4'd5,  64'hFFFF_FFFF_FFFF_8001, 1'b1, 8'd3},
    '{64'hFFFF_FFFF_FFFF_FFFF, 16'h7FFF, 3'd4, 4'd6,  64'h0000_0000_0000_7FFF, 1'b1, 8'd3},
    // R4 shift by 16
    '{64'hFFFF_FFFF_FFFF_FFFF, 16'h8001, 3'd5, 4'd7,  64'hFFFF_FFFF_8001_0000, 1'b1, 8'd4},
    // R5 shift by 32 and 48
    '{64'hFFFF_FFFF_FFFF_FFFF, 16'h1234, 3'd6, 4'd8,  64'h0000_1234_0000_0000, 1'b1, 8'd5},
    '{64'h0000_0000_0000_0000, 16'hF000, 3'd6, 4'd9,  64'hFFFF_F000_0000_0000, 1'b1, 8'd5},
    '{64'hFFFF_FFFF_FFFF_FFFF, 16'h8000, 3'd7, 4'd10, 64'h8000_0000_0000_0000, 1'b1, 8'd5},
    '{64'hFFFF_FFFF_FFFF_FFFF, 16'h0001, 3'd7, 4'd11, 64'h0001_0000_0000_0000, 1'b1, 8'd5},
    // R6 zero register destination
    '{64'h1111_2222_3333_4444, 16'hABCD, 3'd0, 4'd0,  64'h0,                   1'b0, 8'd6},
    '{64'hFFFF_FFFF_FFFF_FFFF, 16'h8001, 3'd5, 4'd0,  64'h0,                   1'b0, 8'd6}
  };

  task automatic check(input string reqTag, input logic [63:0] expV, input logic expWe);
    testsRun++;
    if (newValue !== expV || writeEn !== expWe) begin
      testsFailed++;
      $display("FAIL %s: newValue=%h writeEn=%b expected newValue=%h writeEn=%b",
               reqTag, newValue, writeEn, expV, expWe);
    end
  endtask

  task automatic apply(input logic [63:0] o, input logic [15:0] i,
                       input logic [2:0] op, input logic [3:0] d);
    @(negedge clk);
    oldValue = o; immValue = i; opSel = op; destIdx = d;
    #2;
  endtask

  initial begin : watchdog
    #100000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    oldValue = '0; immValue = '0; opSel = '0; destIdx = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    #2;
    // R6: idle state with all-zero inputs targets the zero register
    check("R6 idle", 64'h0, 1'b0);

    for (int k = 0; k < NVEC; k++) begin
      apply(VECS[k].oldV, VECS[k].imm, VECS[k].op, VECS[k].dest);
      check($sformatf("R%0d vec%0d", VECS[k].req, k), VECS[k].expV, VECS[k].expWe);
    end

    // R7: every nonzero destination enables the write
    for (int d = 1; d < 16; d++) begin
      apply(64'h0, 16'h0055, 3'd0, 4'(d));
      check($sformatf("R7 dest%0d", d), 64'h0000_0000_0000_0055, 1'b1);
    end

    // R8: outputs follow a second input change before the next rising edge
    apply(64'hAAAA_BBBB_CCCC_DDDD, 16'h0102, 3'd3, 4'd2);
    check("R8 first", 64'h0102_BBBB_CCCC_DDDD, 1'b1);
    opSel = 3'd7;
    #1;
    check("R8 second", 64'h0102_0000_0000_0000, 1'b1);
    destIdx = 4'd0;
    #1;
    check("R8 third", 64'h0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule